// File: doc/BRIEF.md
# Vector Control and Status Register File

This block holds the control and status registers of a vector unit attached to a scalar core and answers the scalar CSR read and write instructions that target them. A request carries a 12-bit CSR address, an XLEN-wide write value and separate read and write strobes. The block answers in the same cycle with the read data, a hit flag that claims the address, and an illegal-access flag. State changes take effect at the next rising clock edge.

The fixed-point saturation flag and the rounding mode can be reached through their own addresses or through a combined status register. All three views read from one copy of the state, so they always agree. The start-index register takes a full-width write and saturates it to a limit instead of truncating it. Two side ports connect the block to the rest of the vector unit. The configuration logic loads the vector length and the vector type through one of them. The datapath raises the saturation flag through the other.

Top module: `vec_csr_file`

## Requirements
- R1: A synchronous active-high reset sets the start index, saturation flag, rounding mode and vector length to zero. It sets the vector type to a value with only bit XLEN-1 set.
- R2: When the read or write strobe is high and the address is one of 0x008 (start index), 0x009 (saturation), 0x00A (rounding mode), 0x00F (combined status), 0xC20 (vector length), 0xC21 (vector type) or 0xC22 (register bytes), the hit flag is high. The read data is then the stored value of that register, zero-extended. In every other case both the hit flag and the read data are zero.
- R3: A write strobe to 0xC20, 0xC21 or 0xC22 raises the illegal-access flag in that cycle and leaves the stored value unchanged. No other access raises the flag.
- R4: A write to 0x009 stores bit 0 of the write data as the saturation flag. That flag reads back as bit 0 of 0x00F, and bits 2:1 of 0x00F do not change.
- R5: A write to 0x00A stores bits 1:0 of the write data as the rounding mode. The mode reads back as bits 2:1 of 0x00F, and the saturation flag does not change.
- R6: A write to 0x00F sets the saturation flag from bit 0 and the rounding mode from bits 2:1 in the same edge. Every bit of 0x00F above bit 2 reads as zero.
- R7: A write to 0x008 stores the smaller of the full XLEN write value and 65535.
- R8: An access to any other address leaves every register unchanged.
- R9: Reads of 0xC22 return VLEN/8, fixed by a parameter.
- R10: A high saturation-set input ORs a one into the saturation flag at the next edge. The flag stays set until a CSR write clears it.
- R11: In a cycle with a CSR write to 0x009, 0x00A or 0x00F, the saturation-set input is ignored and the write decides the flag.
- R12: A high configuration-valid strobe loads the vector length and the full vector type from the configuration port at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 12 | CSR address of the request |
| csr_wdata | input | XLEN | Write value |
| csr_rd | input | 1 | Read strobe |
| csr_wr | input | 1 | Write strobe |
| csr_rdata | output | XLEN | Read data, zero when not claimed |
| csr_hit | output | 1 | Address belongs to this block |
| csr_illegal | output | 1 | Write to a read-only register |
| cfg_valid | input | 1 | Load strobe for vector length and type |
| cfg_vl | input | XLEN | New vector length |
| cfg_vtype | input | XLEN | New vector type |
| sat_set | input | 1 | Saturation event from the datapath |

## Verification
The assertions assume that reset is high from time zero for at least one edge. They also assume the inputs are stable and known around each rising edge, and that only the configuration port writes the length and type registers. The stimulus meets these assumptions. It drives every input on the falling edge and holds reset for several cycles. It also combines the configuration strobe with CSR writes only where a requirement defines the result. Saturation events are applied both alone and together with each of the three fixed-point writes, which covers both sides of the priority rule.

// File: rtl/vcsr_pkg.sv
package vcsr_pkg;

    localparam logic [11:0] ADDR_VSTART = 12'h008;
    localparam logic [11:0] ADDR_VXSAT  = 12'h009;
    localparam logic [11:0] ADDR_VXRM   = 12'h00A;
    localparam logic [11:0] ADDR_VCSR   = 12'h00F;
    localparam logic [11:0] ADDR_VL     = 12'hC20;
    localparam logic [11:0] ADDR_VTYPE  = 12'hC21;
    localparam logic [11:0] ADDR_VLENB  = 12'hC22;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_START,
        SEL_SAT,
        SEL_RMODE,
        SEL_FXSTAT,
        SEL_LEN,
        SEL_TYPE,
        SEL_BYTES
    } csr_sel_e;

    typedef struct packed {
        logic       sat;
        logic [1:0] rmode;
    } fx_state_t;

    function automatic logic sel_is_ro(input csr_sel_e s);
        return (s == SEL_LEN) || (s == SEL_TYPE) || (s == SEL_BYTES);
    endfunction

    function automatic logic sel_is_fx(input csr_sel_e s);
        return (s == SEL_SAT) || (s == SEL_RMODE) || (s == SEL_FXSTAT);
    endfunction

endpackage

// File: rtl/vcsr_decode.sv
module vcsr_decode
    import vcsr_pkg::*;
(
    input  logic [11:0] addr,
    output csr_sel_e    sel
);
    always_comb begin
        unique case (addr)
            ADDR_VSTART: sel = SEL_START;
            ADDR_VXSAT:  sel = SEL_SAT;
            ADDR_VXRM:   sel = SEL_RMODE;
            ADDR_VCSR:   sel = SEL_FXSTAT;
            ADDR_VL:     sel = SEL_LEN;
            ADDR_VTYPE:  sel = SEL_TYPE;
            ADDR_VLENB:  sel = SEL_BYTES;
            default:     sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/vcsr_fxstate.sv
module vcsr_fxstate
    import vcsr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  csr_sel_e  sel,
    input  logic [2:0] wbits,
    input  logic      sat_set,
    output fx_state_t fx_q
);
    fx_state_t fx_d;
    logic      fx_wr;

    assign fx_wr = wr_en && sel_is_fx(sel);

    always_comb begin
        fx_d = fx_q;
        if (fx_wr) begin
            case (sel)
                SEL_SAT:    fx_d.sat   = wbits[0];
                SEL_RMODE:  fx_d.rmode = wbits[1:0];
                SEL_FXSTAT: begin
                    fx_d.sat   = wbits[0];
                    fx_d.rmode = wbits[2:1];
                end
                default: ;
            endcase
        end else if (sat_set) begin
            fx_d.sat = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) fx_q <= '0;
        else     fx_q <= fx_d;
    end
endmodule

// File: rtl/vcsr_cfgstate.sv
module vcsr_cfgstate
    import vcsr_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int VSTART_MAX = 65535,
    parameter int VSTART_W   = $clog2(VSTART_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  csr_sel_e            sel,
    input  logic [XLEN-1:0]     wdata,
    input  logic                cfg_valid,
    input  logic [XLEN-1:0]     cfg_vl,
    input  logic [XLEN-1:0]     cfg_vtype,
    output logic [VSTART_W-1:0] vstart_q,
    output logic [XLEN-1:0]     vl_q,
    output logic [XLEN-1:0]     vtype_q
);
    localparam logic [XLEN-1:0] LIMIT_X   = XLEN'(VSTART_MAX);
    localparam logic [XLEN-1:0] VTYPE_RST = {1'b1, {(XLEN-1){1'b0}}};

    logic [VSTART_W-1:0] start_clamped;

    always_comb begin
        if (wdata > LIMIT_X) start_clamped = VSTART_W'(VSTART_MAX);
        else                 start_clamped = wdata[VSTART_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vstart_q <= '0;
        end else if (wr_en && sel == SEL_START) begin
            vstart_q <= start_clamped;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vl_q    <= '0;
            vtype_q <= VTYPE_RST;
        end else if (cfg_valid) begin
            vl_q    <= cfg_vl;
            vtype_q <= cfg_vtype;
        end
    end
endmodule

// File: rtl/vec_csr_file.sv
module vec_csr_file
    import vcsr_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int VLEN       = 128,
    parameter int VSTART_MAX = 65535
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [11:0]     csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic            csr_rd,
    input  logic            csr_wr,
    output logic [XLEN-1:0] csr_rdata,
    output logic            csr_hit,
    output logic            csr_illegal,
    input  logic            cfg_valid,
    input  logic [XLEN-1:0] cfg_vl,
    input  logic [XLEN-1:0] cfg_vtype,
    input  logic            sat_set
);
    localparam int              VSTART_W  = $clog2(VSTART_MAX + 1);
    localparam logic [XLEN-1:0] VLENB_VAL = XLEN'(VLEN / 8);

    csr_sel_e            sel;
    logic                wr_ok;
    fx_state_t           fx_q;
    logic                vxsat_q;
    logic [1:0]          vxrm_q;
    logic [VSTART_W-1:0] vstart_q;
    logic [XLEN-1:0]     vl_q;
    logic [XLEN-1:0]     vtype_q;

    vcsr_decode u_dec (
        .addr (csr_addr),
        .sel  (sel)
    );

    assign csr_hit     = (csr_rd || csr_wr) && (sel != SEL_NONE);
    assign csr_illegal = csr_wr && sel_is_ro(sel);
    assign wr_ok       = csr_wr && (sel != SEL_NONE) && !sel_is_ro(sel);

    vcsr_fxstate u_fx (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_ok),
        .sel     (sel),
        .wbits   (csr_wdata[2:0]),
        .sat_set (sat_set),
        .fx_q    (fx_q)
    );

    assign vxsat_q = fx_q.sat;
    assign vxrm_q  = fx_q.rmode;

    vcsr_cfgstate #(
        .XLEN       (XLEN),
        .VSTART_MAX (VSTART_MAX),
        .VSTART_W   (VSTART_W)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_ok),
        .sel       (sel),
        .wdata     (csr_wdata),
        .cfg_valid (cfg_valid),
        .cfg_vl    (cfg_vl),
        .cfg_vtype (cfg_vtype),
        .vstart_q  (vstart_q),
        .vl_q      (vl_q),
        .vtype_q   (vtype_q)
    );

    always_comb begin
        csr_rdata = '0;
        if (csr_hit) begin
            case (sel)
                SEL_START:  csr_rdata = XLEN'(vstart_q);
                SEL_SAT:    csr_rdata = XLEN'(vxsat_q);
                SEL_RMODE:  csr_rdata = XLEN'(vxrm_q);
                SEL_FXSTAT: csr_rdata = XLEN'({vxrm_q, vxsat_q});
                SEL_LEN:    csr_rdata = vl_q;
                SEL_TYPE:   csr_rdata = vtype_q;
                SEL_BYTES:  csr_rdata = VLENB_VAL;
                default:    csr_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/vec_csr_file_chk.sv
module vec_csr_file_chk #(
    parameter int XLEN       = 64,
    parameter int VLEN       = 128,
    parameter int VSTART_MAX = 65535,
    parameter int VSTART_W   = 16
) (
    input logic                clk,
    input logic                rst,
    input logic [11:0]         csr_addr,
    input logic [XLEN-1:0]     csr_wdata,
    input logic                csr_rd,
    input logic                csr_wr,
    input logic [XLEN-1:0]     csr_rdata,
    input logic                csr_hit,
    input logic                csr_illegal,
    input logic                cfg_valid,
    input logic [XLEN-1:0]     cfg_vl,
    input logic [XLEN-1:0]     cfg_vtype,
    input logic                sat_set,
    input logic [VSTART_W-1:0] vstart_q,
    input logic                vxsat_q,
    input logic [1:0]          vxrm_q,
    input logic [XLEN-1:0]     vl_q,
    input logic [XLEN-1:0]     vtype_q
);
    logic [XLEN-1:0] clamp_w;
    logic            fx_addr;

    assign clamp_w = (csr_wdata > XLEN'(VSTART_MAX)) ? XLEN'(VSTART_MAX) : csr_wdata;
    assign fx_addr = (csr_addr == 12'h009) || (csr_addr == 12'h00A) || (csr_addr == 12'h00F);

    AST_ILLEGAL_IS_CLAIMED_WRITE: assert property (@(posedge clk) disable iff (rst)
        csr_illegal |-> (csr_wr && csr_hit)); // R3

    AST_RO_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (csr_wr && !cfg_valid && (csr_addr == 12'hC20 || csr_addr == 12'hC21))
        |=> ($stable(vl_q) && $stable(vtype_q))); // R3

    AST_VXRM_KEEPS_SAT: assert property (@(posedge clk) disable iff (rst)
        (csr_wr && csr_addr == 12'h00A) |=> (vxsat_q == $past(vxsat_q))); // R5

    AST_VSTART_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (csr_wr && csr_addr == 12'h008) |=> (XLEN'(vstart_q) == $past(clamp_w))); // R7

    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((csr_rd || csr_wr) && !csr_hit && !sat_set && !cfg_valid)
        |=> ($stable(vstart_q) && $stable(vxsat_q) && $stable(vxrm_q)
             && $stable(vl_q) && $stable(vtype_q))); // R8

    AST_VLENB_CONST: assert property (@(posedge clk) disable iff (rst)
        (csr_rd && csr_addr == 12'hC22) |-> (csr_rdata == XLEN'(VLEN / 8))); // R9

    AST_SAT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (sat_set && !(csr_wr && fx_addr)) |=> vxsat_q); // R10

    AST_WRITE_BEATS_SAT: assert property (@(posedge clk) disable iff (rst)
        (sat_set && csr_wr && csr_addr == 12'h009) |=> (vxsat_q == $past(csr_wdata[0]))); // R11

    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst)
        cfg_valid |=> ((vl_q == $past(cfg_vl)) && (vtype_q == $past(cfg_vtype)))); // R12
endmodule

bind vec_csr_file vec_csr_file_chk #(
    .XLEN       (XLEN),
    .VLEN       (VLEN),
    .VSTART_MAX (VSTART_MAX),
    .VSTART_W   (VSTART_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .csr_addr    (csr_addr),
    .csr_wdata   (csr_wdata),
    .csr_rd      (csr_rd),
    .csr_wr      (csr_wr),
    .csr_rdata   (csr_rdata),
    .csr_hit     (csr_hit),
    .csr_illegal (csr_illegal),
    .cfg_valid   (cfg_valid),
    .cfg_vl      (cfg_vl),
    .cfg_vtype   (cfg_vtype),
    .sat_set     (sat_set),
    .vstart_q    (vstart_q),
    .vxsat_q     (vxsat_q),
    .vxrm_q      (vxrm_q),
    .vl_q        (vl_q),
    .vtype_q     (vtype_q)
);

// File: tb/vec_csr_file_tb_top.sv
module vec_csr_file_tb_top;
    localparam int XLEN = 64;
    localparam int VLEN = 128;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [11:0]     csr_addr = '0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic            csr_rd = 1'b0;
    logic            csr_wr = 1'b0;
    logic [XLEN-1:0] csr_rdata;
    logic            csr_hit;
    logic            csr_illegal;
    logic            cfg_valid = 1'b0;
    logic [XLEN-1:0] cfg_vl = '0;
    logic [XLEN-1:0] cfg_vtype = '0;
    logic            sat_set = 1'b0;

    always #10 clk = ~clk;

    vec_csr_file #(.XLEN(XLEN), .VLEN(VLEN)) dut_i (
        .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rd(csr_rd), .csr_wr(csr_wr), .csr_rdata(csr_rdata),
        .csr_hit(csr_hit), .csr_illegal(csr_illegal), .cfg_valid(cfg_valid),
        .cfg_vl(cfg_vl), .cfg_vtype(cfg_vtype), .sat_set(sat_set)
    );

    typedef struct {
        logic [XLEN-1:0] rdata;
        logic            hit;
        logic            ill;
        string           tag;
    } exp_t;

    exp_t q[$];
    event sample_ev;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 0;

    // reference state
    logic [XLEN-1:0] m_vstart, m_vl, m_vtype;
    logic            m_sat;
    logic [1:0]      m_rm;

    function automatic logic known(input logic [11:0] a);
        return a == 12'h008 || a == 12'h009 || a == 12'h00A || a == 12'h00F ||
               a == 12'hC20 || a == 12'hC21 || a == 12'hC22;
    endfunction

    function automatic logic [XLEN-1:0] cur_val(input logic [11:0] a);
        case (a)
            12'h008: return m_vstart;
            12'h009: return XLEN'(m_sat);
            12'h00A: return XLEN'(m_rm);
            12'h00F: return XLEN'({m_rm, m_sat});
            12'hC20: return m_vl;
            12'hC21: return m_vtype;
            12'hC22: return XLEN'(VLEN / 8);
            default: return '0;
        endcase
    endfunction

    // monitor: pops expected items and compares against sampled outputs
    initial begin
        forever begin
            @(sample_ev);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_vec++;
                if (csr_rdata !== e.rdata || csr_hit !== e.hit || csr_illegal !== e.ill) begin
                    n_bad++;
                    $display("FAIL %s: rdata=%h hit=%b ill=%b expected rdata=%h hit=%b ill=%b",
                             e.tag, csr_rdata, csr_hit, csr_illegal, e.rdata, e.hit, e.ill);
                end
            end
        end
    end

    // driver: one access per cycle, inputs change on the falling edge
    task automatic access(input logic rd, input logic wr, input logic [11:0] a,
                          input logic [XLEN-1:0] wd, input logic sat,
                          input logic cv, input logic [XLEN-1:0] cvl,
                          input logic [XLEN-1:0] cvt, input string tag);
        exp_t e;
        logic fxw;
        @(negedge clk);
        csr_rd = rd; csr_wr = wr; csr_addr = a; csr_wdata = wd;
        sat_set = sat; cfg_valid = cv; cfg_vl = cvl; cfg_vtype = cvt;
        #1;
        e.hit   = (rd || wr) && known(a);
        e.ill   = wr && (a == 12'hC20 || a == 12'hC21 || a == 12'hC22);
        e.rdata = e.hit ? cur_val(a) : '0;
        e.tag   = tag;
        q.push_back(e);
        ->sample_ev;
        // update reference model for the coming edge
        fxw = wr && (a == 12'h009 || a == 12'h00A || a == 12'h00F);
        if (cv) begin m_vl = cvl; m_vtype = cvt; end
        if (wr) begin
            case (a)
                12'h008: m_vstart = (wd > 64'd65535) ? 64'd65535 : wd;
                12'h009: m_sat = wd[0];
                12'h00A: m_rm = wd[1:0];
                12'h00F: begin m_sat = wd[0]; m_rm = wd[2:1]; end
                default: ;
            endcase
        end
        if (sat && !fxw) m_sat = 1'b1;
    endtask

    task automatic rd_chk(input logic [11:0] a, input string tag);
        access(1, 0, a, '0, 0, 0, '0, '0, tag);
    endtask

    task automatic wr_op(input logic [11:0] a, input logic [XLEN-1:0] wd, input string tag);
        access(0, 1, a, wd, 0, 0, '0, '0, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        repeat (2) @(negedge clk);
        m_vstart = '0; m_vl = '0; m_vtype = 64'h8000_0000_0000_0000;
        m_sat = 0; m_rm = 0;
        rst = 1'b0;

        // R1 reset state, R2 reads of every register
        rd_chk(12'h008, "R1 vstart reset");
        rd_chk(12'h009, "R1 vxsat reset");
        rd_chk(12'h00A, "R1 vxrm reset");
        rd_chk(12'h00F, "R1 vcsr reset");
        rd_chk(12'hC20, "R1 vl reset");
        rd_chk(12'hC21, "R1 vtype reset");
        rd_chk(12'hC22, "R9 vlenb constant");

        // R12 configuration load, R2 readback
        access(0, 0, 12'h000, '0, 0, 1, 64'd37, 64'h53, "R12 cfg load");
        rd_chk(12'hC20, "R12 vl loaded");
        rd_chk(12'hC21, "R12 vtype loaded");

        // R3 writes to read-only registers
        wr_op(12'hC20, 64'd5, "R3 vl write refused");
        wr_op(12'hC21, 64'h0, "R3 vtype write refused");
        wr_op(12'hC22, 64'd99, "R3 vlenb write refused");
        rd_chk(12'hC20, "R3 vl unchanged");
        rd_chk(12'hC21, "R3 vtype unchanged");
        rd_chk(12'hC22, "R3 R9 vlenb unchanged");

        // R4 saturation flag view
        wr_op(12'h00A, 64'd3, "R5 preset rounding mode");
        wr_op(12'h009, 64'hFFFF_FFFF_FFFF_FFFF, "R4 vxsat write");
        rd_chk(12'h009, "R4 vxsat masked");
        rd_chk(12'h00F, "R4 vcsr bit0 mirrors, bits2:1 kept");
        wr_op(12'h009, 64'hFFFE, "R4 vxsat clear");
        rd_chk(12'h00F, "R4 vcsr after clear");

        // R5 rounding mode view
        wr_op(12'h009, 64'd1, "R5 preset vxsat");
        wr_op(12'h00A, 64'hFE, "R5 vxrm write");
        rd_chk(12'h00A, "R5 vxrm masked");
        rd_chk(12'h00F, "R5 vcsr bits2:1 mirror, bit0 kept");

        // R6 combined status
        wr_op(12'h00F, 64'hFFFF_FFFA, "R6 vcsr write");
        rd_chk(12'h00F, "R6 vcsr upper bits cleared");
        rd_chk(12'h009, "R6 vxsat from bit0");
        rd_chk(12'h00A, "R6 vxrm from bits2:1");
        wr_op(12'h00F, 64'h5, "R6 vcsr write 101");
        rd_chk(12'h009, "R6 vxsat set");
        rd_chk(12'h00A, "R6 vxrm 10");

        // R7 start index saturation
        wr_op(12'h008, 64'd100, "R7 vstart small");
        rd_chk(12'h008, "R7 vstart 100");
        wr_op(12'h008, 64'd65535, "R7 vstart at limit");
        rd_chk(12'h008, "R7 vstart 65535");
        wr_op(12'h008, 64'd65536, "R7 vstart above limit");
        rd_chk(12'h008, "R7 vstart clamps");
        wr_op(12'h008, 64'hFFFF_FFFF_FFFF_FFFF, "R7 vstart all ones");
        rd_chk(12'h008, "R7 vstart clamps all ones");
        wr_op(12'h008, 64'h1_0000_0007, "R7 vstart upper bits");
        rd_chk(12'h008, "R7 vstart no truncation");

        // R8 unclaimed addresses
        access(1, 1, 12'h00B, 64'hFFFF, 0, 0, '0, '0, "R8 unknown write");
        access(1, 1, 12'hC23, 64'h1, 0, 0, '0, '0, "R8 unknown write 2");
        access(1, 1, 12'h108, 64'h7, 0, 0, '0, '0, "R8 alias-looking address");
        rd_chk(12'h008, "R8 vstart unchanged");
        rd_chk(12'h00F, "R8 vcsr unchanged");
        rd_chk(12'hC20, "R8 vl unchanged");

        // R10 sticky saturation from the datapath
        wr_op(12'h009, 64'd0, "R10 clear vxsat");
        access(0, 0, 12'h000, '0, 1, 0, '0, '0, "R10 sat event");
        rd_chk(12'h00F, "R10 vcsr bit0 set");
        access(1, 0, 12'h009, '0, 0, 0, '0, '0, "R10 vxsat stays set");
        access(1, 0, 12'h009, '0, 1, 0, '0, '0, "R10 sat event again");
        rd_chk(12'h009, "R10 still set");

        // R11 CSR write wins over the datapath
        access(0, 1, 12'h009, 64'd0, 1, 0, '0, '0, "R11 vxsat write vs sat");
        rd_chk(12'h009, "R11 vxsat written zero");
        access(0, 1, 12'h00F, 64'd2, 1, 0, '0, '0, "R11 vcsr write vs sat");
        rd_chk(12'h00F, "R11 vcsr written value");
        access(0, 1, 12'h00A, 64'd3, 1, 0, '0, '0, "R11 vxrm write vs sat");
        rd_chk(12'h00F, "R11 vxsat untouched by vxrm write");
        access(0, 1, 12'h008, 64'd9, 1, 0, '0, '0, "R10 sat with vstart write");
        rd_chk(12'h009, "R10 sat applies beside vstart write");

        // R12 load with refused write in same cycle
        access(0, 1, 12'hC20, 64'd1, 0, 1, 64'd64, 64'hD8, "R3 R12 cfg with ro write");
        rd_chk(12'hC20, "R12 vl from cfg port");
        rd_chk(12'hC21, "R12 vtype from cfg port");

        // R1 reset again
        @(negedge clk);
        csr_rd = 0; csr_wr = 0; sat_set = 0; cfg_valid = 0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_vstart = '0; m_vl = '0; m_vtype = 64'h8000_0000_0000_0000;
        m_sat = 0; m_rm = 0;
        rd_chk(12'h00F, "R1 vcsr after reset");
        rd_chk(12'hC21, "R1 vtype after reset");
        rd_chk(12'h008, "R1 vstart after reset");

        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule